// File: doc/BRIEF.md
# Network Address ROM Command Handler

This block sits between the bit-level engine of a single-wire multidrop bus and the function-command layer. After every bus reset it assembles the first command byte sent by the master. It then runs the addressing step that byte asks for: read, match, skip or search, against a fixed 64-bit device address. The address is built from a family code and a serial number given as parameters. Its top byte is an 8-bit CRC that the block computes from the lower 56 bits at elaboration.

The bit engine reports each finished time slot with a one-cycle `slot_done` pulse. That pulse carries the level sampled on the line in `slot_bit`. While `tx_active` is high, the engine drives `tx_bit` onto the line during the next slot, where a 0 pulls the line low. When addressing succeeds, `selected` rises and stays high until the next bus reset, so that the function-command layer can take over. When addressing fails, the block goes silent and stays silent until the next bus reset.

States: `ST_CMD` collects the command byte. `ST_READ` sends the address. `ST_MATCH` compares the received bits with the address. `ST_SRCH_BIT`, `ST_SRCH_CMP` and `ST_SRCH_DIR` form the search triplet. `ST_SEL` means the device is selected, and `ST_DROP` means it is deselected. Transitions:
- `ST_CMD` to a command state after the 8th bit.
- `ST_READ` to `ST_SEL` after bit 63.
- `ST_MATCH` to `ST_SEL`, or to `ST_DROP` on a mismatch.
- `ST_SRCH_BIT` to `ST_SRCH_CMP` to `ST_SRCH_DIR`, then back to `ST_SRCH_BIT`, or on to `ST_SEL` or `ST_DROP`.
- Any state to `ST_CMD` on `bus_reset`.

Top module: `netaddr_rom_ctrl`

## Requirements
- R1: The address is built as follows. Bits [7:0] hold the FAMILY parameter (default 09h). Bits [55:8] hold the SERIAL parameter. Bits [63:56] hold the address CRC. Address bits are always exchanged in order from bit 0 to bit 63.
- R2: The address CRC starts at 0. The 56 low address bits are shifted in from bit 0 upward. Each step uses feedback = crc[0] XOR data, shifts the CRC right by one, and XORs in 8Ch when the feedback is 1 (polynomial x^8+x^5+x^4+1).
- R3: After command 33h or 39h (command bits are received LSB first), the block holds `tx_active`=1 with `tx_bit` equal to address bit i for slot i, over 64 slots. After the 64th slot, `selected`=1.
- R4: After command 55h, the block compares 64 received slot bits with address bits 0 to 63. If all are equal, `selected` rises after the 64th slot and not before. On the first mismatch the device is deselected.
- R5: Command CCh sets `selected`=1 right after the 8th command slot, with no address exchange.
- R6: After command F0h, each address bit i takes three slots. First the block sends bit i, then the inverse of bit i, both with `tx_active`=1. Then it receives the master's bit with `tx_active`=0. A received bit that differs from bit i deselects the device. Agreement on all 64 bits sets `selected`=1.
- R7: Once `selected` is 1, it stays 1 and `tx_active` stays 0 across any slots until a bus reset.
- R8: An unrecognized command byte deselects the device. While deselected, `tx_active` and `selected` stay 0 for every slot, including slots that carry a valid command byte, until a bus reset.
- R9: A `bus_reset` pulse in any state clears `selected` and `tx_active` on the next cycle and restarts command collection. After `rst_n`, the block is in the same command-collection state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | One-cycle pulse: a bus reset was detected |
| slot_done | input | 1 | One-cycle pulse: a time slot has finished |
| slot_bit | input | 1 | Line level sampled in the finished slot |
| tx_active | output | 1 | The device drives the next slot |
| tx_bit | output | 1 | The bit to drive in the next slot when `tx_active` is 1 |
| selected | output | 1 | Addressing succeeded; the function layer owns the bus |

## Verification
Every output is decoded directly from the state register. The state register and the bit counter update on the clock edge that samples `slot_done` or `bus_reset`. A result is therefore due on the first edge after the stimulus pulse, and it holds until the next pulse. The bench drives each pulse for one cycle starting on a falling edge. It reads the outputs on the following falling edge, after the capturing rising edge. For the transmit checks, it reads `tx_active` and `tx_bit` before issuing each slot, because those values govern the slot that is about to run.

// File: rtl/netaddr_pkg.sv
package netaddr_pkg;

    typedef enum logic [2:0] {
        ST_CMD,
        ST_READ,
        ST_MATCH,
        ST_SRCH_BIT,
        ST_SRCH_CMP,
        ST_SRCH_DIR,
        ST_SEL,
        ST_DROP
    } na_state_t;

    localparam logic [7:0] OP_READ_A = 8'h33;
    localparam logic [7:0] OP_READ_B = 8'h39;
    localparam logic [7:0] OP_MATCH  = 8'h55;
    localparam logic [7:0] OP_SKIP   = 8'hCC;
    localparam logic [7:0] OP_SEARCH = 8'hF0;

    // Serial CRC over the 56 low address bits, bit 0 first (reflected 31h form)
    function automatic logic [7:0] addr_crc(input logic [55:0] body);
        logic [7:0] c;
        logic       fb;
        c = 8'h00;
        for (int i = 0; i < 56; i++) begin
            fb = c[0] ^ body[i];
            c  = c >> 1;
            if (fb) c = c ^ 8'h8C;
        end
        return c;
    endfunction

endpackage

// File: rtl/netaddr_addr_rom.sv
module netaddr_addr_rom #(
    parameter logic [7:0]  FAMILY = 8'h09,
    parameter logic [47:0] SERIAL = 48'hA5C3_1E72_0B94
) (
    output logic [63:0] addr
);
    import netaddr_pkg::*;

    localparam logic [55:0] BODY = {SERIAL, FAMILY};
    localparam logic [7:0]  CRC  = addr_crc(BODY);

    assign addr = {CRC, BODY};
endmodule

// File: rtl/netaddr_cmd_decode.sv
module netaddr_cmd_decode (
    input  logic [7:0]             cmd_byte,
    output netaddr_pkg::na_state_t next_state
);
    import netaddr_pkg::*;

    always_comb begin
        unique case (cmd_byte)
            OP_READ_A, OP_READ_B: next_state = ST_READ;
            OP_MATCH:             next_state = ST_MATCH;
            OP_SKIP:              next_state = ST_SEL;
            OP_SEARCH:            next_state = ST_SRCH_BIT;
            default:              next_state = ST_DROP;
        endcase
    end
endmodule

// File: rtl/netaddr_bit_cnt.sv
module netaddr_bit_cnt #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/netaddr_rom_ctrl.sv
module netaddr_rom_ctrl #(
    parameter logic [7:0]  FAMILY = 8'h09,
    parameter logic [47:0] SERIAL = 48'hA5C3_1E72_0B94
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_reset,
    input  logic slot_done,
    input  logic slot_bit,
    output logic tx_active,
    output logic tx_bit,
    output logic selected
);
    import netaddr_pkg::*;

    localparam int ADDR_W   = 64;
    localparam int CMD_BITS = 8;
    localparam int IDX_W    = $clog2(ADDR_W);

    na_state_t         state, nxt, dec_state;
    logic [ADDR_W-1:0] addr;
    logic [IDX_W-1:0]  cnt;
    logic              cnt_clr, cnt_inc, cmd_shift;
    logic [CMD_BITS-1:0] cmd_sr;
    logic [CMD_BITS-1:0] cmd_byte;
    logic              cur_bit, last_bit, cmd_last;

    netaddr_addr_rom #(.FAMILY(FAMILY), .SERIAL(SERIAL)) rom_i (.addr(addr));

    netaddr_bit_cnt #(.W(IDX_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc), .cnt(cnt)
    );

    assign cmd_byte = {slot_bit, cmd_sr[CMD_BITS-1:1]};

    netaddr_cmd_decode dec_i (.cmd_byte(cmd_byte), .next_state(dec_state));

    assign cur_bit  = addr[cnt];
    assign last_bit = (cnt == IDX_W'(ADDR_W - 1));
    assign cmd_last = (cnt == IDX_W'(CMD_BITS - 1));

    // Next-state and counter control
    always_comb begin
        nxt       = state;
        cnt_clr   = 1'b0;
        cnt_inc   = 1'b0;
        cmd_shift = 1'b0;
        if (bus_reset) begin
            nxt     = ST_CMD;
            cnt_clr = 1'b1;
        end else if (slot_done) begin
            unique case (state)
                ST_CMD: begin
                    cmd_shift = 1'b1;
                    if (cmd_last) begin
                        nxt     = dec_state;
                        cnt_clr = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
                ST_READ: begin
                    if (last_bit) begin
                        nxt     = ST_SEL;
                        cnt_clr = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
                ST_MATCH: begin
                    if (slot_bit != cur_bit) begin
                        nxt = ST_DROP;
                    end else if (last_bit) begin
                        nxt     = ST_SEL;
                        cnt_clr = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
                ST_SRCH_BIT: nxt = ST_SRCH_CMP;
                ST_SRCH_CMP: nxt = ST_SRCH_DIR;
                ST_SRCH_DIR: begin
                    if (slot_bit != cur_bit) begin
                        nxt = ST_DROP;
                    end else if (last_bit) begin
                        nxt     = ST_SEL;
                        cnt_clr = 1'b1;
                    end else begin
                        nxt     = ST_SRCH_BIT;
                        cnt_inc = 1'b1;
                    end
                end
                ST_SEL, ST_DROP: nxt = state;
                default: nxt = ST_DROP;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_CMD;
            cmd_sr <= '0;
        end else begin
            state <= nxt;
            if (cmd_shift) cmd_sr <= cmd_byte;
        end
    end

    // Outputs
    always_comb begin
        tx_active = 1'b0;
        tx_bit    = 1'b1;
        selected  = 1'b0;
        unique case (state)
            ST_READ, ST_SRCH_BIT: begin
                tx_active = 1'b1;
                tx_bit    = cur_bit;
            end
            ST_SRCH_CMP: begin
                tx_active = 1'b1;
                tx_bit    = ~cur_bit;
            end
            ST_SEL: selected = 1'b1;
            default: ;
        endcase
    end

    // R9
    bus_reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (!selected && !tx_active));

    // R5
    skip_selects_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CMD && slot_done && !bus_reset && cmd_last && cmd_byte == OP_SKIP)
        |=> selected);

    // R6
    search_complement_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SRCH_BIT && slot_done && !bus_reset)
        |=> (tx_active && tx_bit != $past(tx_bit)));

    // R7
    selected_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (selected && !bus_reset) |=> (selected && !tx_active));

    // R8
    dropped_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DROP && !bus_reset) |=> (!selected && !tx_active));

    // R4
    match_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MATCH && slot_done && !bus_reset && slot_bit != cur_bit)
        |=> !selected);

endmodule

// File: tb/netaddr_rom_ctrl_tb.sv
module netaddr_rom_ctrl_tb_top;

    localparam logic [7:0]  FAM = 8'h09;
    localparam logic [47:0] SER = 48'hA5C3_1E72_0B94;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_reset = 1'b0;
    logic slot_done = 1'b0;
    logic slot_bit = 1'b1;
    logic tx_active, tx_bit, selected;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    logic [63:0] exp_addr;

    always #5 clk = ~clk;

    netaddr_rom_ctrl #(.FAMILY(FAM), .SERIAL(SER)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
        .slot_done(slot_done), .slot_bit(slot_bit),
        .tx_active(tx_active), .tx_bit(tx_bit), .selected(selected)
    );

    // Independent CRC: shift-register form with explicit taps
    function automatic logic [7:0] ref_crc(input logic [55:0] d);
        logic [7:0] c = 8'h00;
        logic fb;
        for (int i = 0; i < 56; i++) begin
            fb = c[0] ^ d[i];
            c  = {fb, c[7:1]};
            c[3] = c[3] ^ fb;
            c[2] = c[2] ^ fb;
        end
        return c;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        slot_done = 1'b1;
        slot_bit  = b;
        @(negedge clk);
        slot_done = 1'b0;
        slot_bit  = 1'b1;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_bit(v[i]);
    endtask

    task automatic do_bus_reset();
        @(negedge clk);
        bus_reset = 1'b1;
        @(negedge clk);
        bus_reset = 1'b0;
        chk("R9 reset clears selected", {63'd0, selected}, 64'd0);
        chk("R9 reset clears tx_active", {63'd0, tx_active}, 64'd0);
    endtask

    task automatic t_read(input logic [7:0] op);
        int bad = 0;
        do_bus_reset();
        send_byte(op);
        for (int i = 0; i < 64; i++) begin
            if (!(tx_active === 1'b1 && tx_bit === exp_addr[i])) bad++;
            if (i == 63) chk("R4 not selected before end of read", {63'd0, selected}, 64'd0);
            send_bit(tx_bit);
        end
        chk("R3 read bits sent LSB first", bad, 0);
        chk("R3 selected after read", {63'd0, selected}, 64'd1);
    endtask

    task automatic t_skip();
        do_bus_reset();
        send_byte(8'hCC);
        chk("R5 skip selects", {63'd0, selected}, 64'd1);
        send_byte(8'h33);
        chk("R7 selected held", {63'd0, selected}, 64'd1);
        chk("R7 no transmit while selected", {63'd0, tx_active}, 64'd0);
    endtask

    task automatic t_match(input int bad_at);
        do_bus_reset();
        send_byte(8'h55);
        for (int i = 0; i < 64; i++) begin
            if (i == 63 && bad_at < 0)
                chk("R4 not selected before bit 63", {63'd0, selected}, 64'd0);
            send_bit(i == bad_at ? ~exp_addr[i] : exp_addr[i]);
        end
        if (bad_at < 0) begin
            chk("R4 match selects", {63'd0, selected}, 64'd1);
        end else begin
            chk("R4 mismatch not selected", {63'd0, selected}, 64'd0);
            send_byte(8'hF0);
            send_bit(1'b1);
            chk("R8 silent after mismatch", {62'd0, tx_active, selected}, 64'd0);
        end
    endtask

    task automatic t_search(input int bad_at);
        int bad = 0;
        do_bus_reset();
        send_byte(8'hF0);
        for (int i = 0; i < 64; i++) begin
            if (!(tx_active === 1'b1 && tx_bit === exp_addr[i])) bad++;
            send_bit(tx_bit);
            if (!(tx_active === 1'b1 && tx_bit === ~exp_addr[i])) bad++;
            send_bit(tx_bit);
            if (tx_active !== 1'b0) bad++;
            send_bit(i == bad_at ? ~exp_addr[i] : exp_addr[i]);
            if (i == bad_at) break;
        end
        chk("R6 search triplet bits", bad, 0);
        if (bad_at < 0) begin
            chk("R6 search selects", {63'd0, selected}, 64'd1);
        end else begin
            chk("R6 search drop not selected", {63'd0, selected}, 64'd0);
            send_bit(1'b1);
            send_bit(1'b1);
            chk("R6 silent after drop", {63'd0, tx_active}, 64'd0);
        end
    endtask

    task automatic t_unknown();
        do_bus_reset();
        send_byte(8'hA5);
        chk("R8 unknown not selected", {63'd0, selected}, 64'd0);
        send_byte(8'h33);
        chk("R8 ignores later read", {63'd0, tx_active}, 64'd0);
        send_byte(8'hCC);
        chk("R8 ignores later skip", {63'd0, selected}, 64'd0);
    endtask

    task automatic t_reset_mid();
        do_bus_reset();
        send_byte(8'h33);
        for (int i = 0; i < 20; i++) send_bit(tx_bit);
        chk("R3 transmitting mid read", {63'd0, tx_active}, 64'd1);
        do_bus_reset();
        send_byte(8'hCC);
        chk("R9 command restart after reset", {63'd0, selected}, 64'd1);
        do_bus_reset();
        send_byte(8'h55);
        send_bit(exp_addr[0]);
        do_bus_reset();
        send_byte(8'hCC);
        chk("R9 reset out of match", {63'd0, selected}, 64'd1);
    endtask

    initial begin
        exp_addr = {ref_crc({SER, FAM}), SER, FAM};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 reset state selected", {63'd0, selected}, 64'd0);
        chk("R9 reset state tx_active", {63'd0, tx_active}, 64'd0);
        send_byte(8'hCC);
        chk("R9 command collection after rst_n", {63'd0, selected}, 64'd1);
        t_read(8'h33);
        t_read(8'h39);
        chk("R1 family byte", exp_addr[7:0], 64'h09);
        chk("R2 crc byte", exp_addr[63:56], ref_crc({SER, FAM}));
        t_skip();
        t_match(-1);
        t_match(40);
        t_match(0);
        t_search(-1);
        t_search(10);
        t_search(63);
        t_unknown();
        t_reset_mid();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule